// File: doc/BRIEF.md
# Four-phase hit time digitizer

The block timestamps the first rising edge of a discriminator output within a readout window opened by a reference strobe. The hit is sampled outside the block on four equally spaced phases of a fast clock, so each base clock cycle delivers a 4-bit phase vector. Bit 0 is the earliest phase and bit 3 is the latest. The block moves this vector into the base clock domain and finds the first 0-to-1 transition. It then forms a time word: a coarse count of base cycles since the strobe, followed by a 2-bit phase index. With a 250 MHz base clock, one count of the word is 1 ns. The binning error is therefore about 0.3 ns rms. At the default width, full scale is far beyond the 1 µs drift window.

Each window produces at most one record. A record is either a time value or an overflow marker. Records are held in a small first-in first-out buffer of their own, apart from any amplitude data, and the readout logic drains it. The head record is presented continuously while the buffer is not empty, and a read pulse removes it.

Top module: `phase_tdc`

## Requirements
- R1: After reset, valid_o is 0, and it stays 0 until a record is written.
- R2: Let n be the number of base clock edges from the edge that samples strobe_i high to the edge that first samples a phase vector containing the rise. The time word is then n in bits [15:2] and the phase index in bits [1:0], with ovf_o at 0.
- R3: The phase index is the lowest bit k of the phase vector that is 1 while the phase before it is 0. For bit 0, the phase before it is bit 3 of the previous cycle's vector. This means 4'b0110 gives 1, 4'b1010 gives 1 and 4'b0101 gives 0.
- R4: A time record becomes visible at the outputs right after the second base clock edge that follows the edge sampling the rising vector. It is not visible one edge earlier.
- R5: Only the first rising edge in a window is recorded. Later rises in the same window produce nothing.
- R6: A rising input while no window is open produces no record.
- R7: An input that is already high when the window opens produces no record while it stays high.
- R8: If no rise occurs by coarse count 2^COARSE_W-1, the block writes one record with ovf_o at 1 and time_o all ones. This record is visible 2^COARSE_W+1 edges after the edge that samples the strobe.
- R9: A rise sampled at n = 2^COARSE_W-1 is still reported as a time record, not as an overflow.
- R10: A new strobe restarts the window with a count of 0. A window abandoned this way produces no record.
- R11: The buffer holds FIFO_DEPTH records (default 4) and returns them oldest first. A record that arrives while the buffer is full is dropped. A pulse on rd_i removes the head, and the head stays unchanged until rd_i is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 4 | Hit sampled on four clock phases, bit 0 earliest; asynchronous to clk_i |
| strobe_i | input | 1 | Reference strobe; opens (or reopens) the measurement window |
| rd_i | input | 1 | Removes the head record from the buffer |
| valid_o | output | 1 | Buffer holds at least one record |
| time_o | output | 16 | Head record time word: coarse count then 2 fine bits |
| ovf_o | output | 1 | Head record is an overflow marker |

## Verification
A time record is due at the outputs two edges after the edge that samples the rising phase vector. That is n+2 edges after the strobe-sampling edge. An overflow record is due 2^COARSE_W+1 edges after that edge. Inputs change on falling edges, so the bench can count these edges exactly. In every window that starts with an empty buffer, the bench checks that valid_o is still 0 one edge before the due edge and holds the record right after it. Coarse values are swept from 0 up through a range of n, and also at full scale, with every fine index. Each expected word is computed as n*4+k.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned NPH    = 4;
  localparam int unsigned FINE_W = 2;

  typedef struct packed {
    logic              hit;
    logic [FINE_W-1:0] fine;
  } rise_t;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tdc_edge.sv
module tdc_edge
  import tdc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] smp_i,
  output rise_t          rise_o
);
  logic           last_q;
  logic [NPH-1:0] prev;
  logic [NPH-1:0] rises;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= smp_i[NPH-1];

  // each phase is compared with the one just before it in time
  assign prev  = {smp_i[NPH-2:0], last_q};
  assign rises = smp_i & ~prev;

  always_comb begin
    rise_o.hit  = |rises;
    rise_o.fine = '0;
    for (int k = NPH - 1; k >= 0; k--)
      if (rises[k]) rise_o.fine = FINE_W'(k);
  end
endmodule

// File: rtl/tdc_window.sv
module tdc_window
  import tdc_pkg::*;
#(
  parameter int unsigned COARSE_W = 14,
  localparam int unsigned TW      = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  rise_t               rise_i,
  output logic                push_o,
  output logic                ovf_o,
  output logic [TW-1:0]       tword_o,
  output logic [COARSE_W-1:0] cnt_o
);
  logic                st_q;
  logic                armed_q;
  logic [COARSE_W-1:0] cnt_q;
  logic                at_max;

  // strobe delayed one cycle to line up with the synchronizer
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= strobe_i;

  assign at_max = &cnt_q;
  assign push_o = armed_q && !st_q && (rise_i.hit || at_max);
  assign ovf_o  = !rise_i.hit;
  assign tword_o = rise_i.hit ? {cnt_q, rise_i.fine} : '1;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (st_q) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (push_o) armed_q <= 1'b0;
      else        cnt_q   <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tdc_fifo.sv
module tdc_fifo #(
  parameter int unsigned W     = 17,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign do_wr   = push_i && (cnt_q != CW'(DEPTH));
  assign do_rd   = pop_i && (cnt_q != '0);
  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
    end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                     mem_q[i] <= '0;
      else if (do_wr && wp_q == AW'(i)) mem_q[i] <= din_i;
  end
endmodule

// File: rtl/phase_tdc.sv
module phase_tdc
  import tdc_pkg::*;
#(
  parameter int unsigned COARSE_W   = 14,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned SYNC_STG   = 2,
  localparam int unsigned TW        = COARSE_W + FINE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] phase_i,
  input  logic           strobe_i,
  input  logic           rd_i,
  output logic           valid_o,
  output logic [TW-1:0]  time_o,
  output logic           ovf_o
);
  logic [NPH-1:0]      smp_w;
  rise_t               rise_w;
  logic                push_w;
  logic                rec_ovf_w;
  logic [TW-1:0]       rec_time_w;
  logic [COARSE_W-1:0] cnt_w;

  tdc_sync #(.W(NPH), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (phase_i),
    .q_o   (smp_w)
  );

  tdc_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_w),
    .rise_o(rise_w)
  );

  tdc_window #(.COARSE_W(COARSE_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .rise_i  (rise_w),
    .push_o  (push_w),
    .ovf_o   (rec_ovf_w),
    .tword_o (rec_time_w),
    .cnt_o   (cnt_w)
  );

  tdc_fifo #(.W(TW + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_w),
    .din_i  ({rec_ovf_w, rec_time_w}),
    .pop_i  (rd_i),
    .valid_o(valid_o),
    .dout_o ({ovf_o, time_o})
  );
endmodule

// File: rtl/phase_tdc_chk.sv
module phase_tdc_chk #(
  parameter int unsigned COARSE_W = 14,
  parameter int unsigned TW       = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_i,
  input logic                valid_o,
  input logic [TW-1:0]       time_o,
  input logic                ovf_o,
  input logic                push_i,
  input logic                push_ovf_i,
  input logic [COARSE_W-1:0] cnt_i
);
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_i |=> valid_o); // R11
  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_i |=> $stable(time_o) && $stable(ovf_o)); // R11
  AST_OVF_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ovf_o |-> &time_o); // R8
  AST_ONE_PER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !push_i); // R5
  AST_OVF_AT_FULL_SCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && push_ovf_i |-> &cnt_i); // R8
endmodule

bind phase_tdc phase_tdc_chk #(.COARSE_W(COARSE_W), .TW(TW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .valid_o   (valid_o),
  .time_o    (time_o),
  .ovf_o     (ovf_o),
  .push_i    (push_w),
  .push_ovf_i(rec_ovf_w),
  .cnt_i     (cnt_w)
);

// File: tb/phase_tdc_tb.sv
module phase_tdc_tb_top;
  localparam int CLK_PERIOD = 4;
  localparam int CW         = 14;
  localparam int TW         = CW + 2;
  localparam int MAXC       = (1 << CW) - 1;
  localparam int DEPTH      = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    vec = '0;
  logic          strobe = 1'b0;
  logic          rd = 1'b0;
  logic          valid;
  logic [TW-1:0] tval;
  logic          ovf;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_tdc #(.COARSE_W(CW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .phase_i (vec),
    .strobe_i(strobe),
    .rd_i    (rd),
    .valid_o (valid),
    .time_o  (tval),
    .ovf_o   (ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe sampled at edge E0; pat first sampled at edge E0+n; returns after E0+n+1
  task automatic launch(int n, logic [3:0] pat);
    @(negedge clk); strobe = 1'b1; vec = (n == 0) ? pat : 4'h0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); strobe = 1'b0;
      if (i == n) vec = pat;
    end
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    vec = 4'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  // full timed window with empty buffer: checks latency and word, then pops
  task automatic timed(string req, int n, logic [3:0] pat, int fine);
    launch(n, pat);
    chk({req, " R4 early"}, valid, 0);
    @(negedge clk);
    chk({req, " R4 due"}, valid, 1);
    chk({req, " R2 word"}, tval, (n << 2) | fine);
    chk({req, " R2 ovf"}, ovf, 0);
    pop();
    chk({req, " R11 drained"}, valid, 0);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle valid", valid, 0);

    // R6: rise with no window open
    vec = 4'hF; repeat (6) @(negedge clk);
    chk("R6 no window", valid, 0);
    settle();

    // R2/R3/R4 sweep of coarse and fine
    for (int n = 0; n < 24; n++)
      for (int f = 0; f < 4; f++)
        timed("R2 sweep", n, 4'(4'hF << f), f);

    // R3 non-thermometer patterns
    timed("R3 0110", 3, 4'b0110, 1);
    timed("R3 1010", 5, 4'b1010, 1);
    timed("R3 0101", 2, 4'b0101, 0);

    // R5: later rises ignored
    launch(4, 4'hF);
    @(negedge clk);
    chk("R5 first", tval, (4 << 2));
    pop();
    vec = 4'h0; repeat (3) @(negedge clk);
    vec = 4'b1100; repeat (6) @(negedge clk);
    chk("R5 second rise ignored", valid, 0);
    settle();

    // R7: input high before window opens
    vec = 4'hF; repeat (4) @(negedge clk);
    strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7 held high", valid, 0);
    settle();

    // R10: restart abandons the open window
    strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    repeat (4) @(negedge clk);
    timed("R10 restart", 7, 4'b1110, 1);
    repeat (4) @(negedge clk);
    chk("R10 single record", valid, 0);

    // R11: order, depth and drop on full
    for (int j = 0; j < DEPTH + 1; j++) begin
      launch(j + 1, 4'b1000);
      @(negedge clk);
      settle();
    end
    for (int j = 0; j < DEPTH; j++) begin
      chk("R11 valid", valid, 1);
      chk("R11 order", tval, ((j + 1) << 2) | 3);
      pop();
    end
    chk("R11 dropped on full", valid, 0);

    // R8: overflow
    @(negedge clk); strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    repeat (MAXC + 1) @(negedge clk);
    chk("R8 early", valid, 0);
    @(negedge clk);
    chk("R8 due", valid, 1);
    chk("R8 flag", ovf, 1);
    chk("R8 word", tval, (1 << TW) - 1);
    pop();
    settle();

    // R9: rise at full-scale count
    timed("R9 full scale", MAXC, 4'b1100, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule